// File: doc/BRIEF.md
# Banked Drive Controller Register Interface

This block is the byte-wide host-facing register file of an optical-drive controller. The host sees four port addresses. A two-bit bank index, held in port 0, selects what ports 1 to 3 reach. Reads and writes to the same port can land on different functions. Through these ports the host issues commands, queues command parameters, drains response bytes and sector data, manages interrupt enables and flags, posts request bytes, and sets four audio mix volumes.

Drive-side logic connects through plain ports. It pushes response and data bytes into their FIFOs, consumes command strobes and parameter bytes, acknowledges commands, and raises interrupt flags. Volume writes go into staging registers. The active volume outputs change only when the host writes the apply bit, and then all four change in the same cycle.

Top module: `drv_regif`

## Requirements
- R1: After reset the bank index is 0, every FIFO is empty, busy is clear, the interrupt enable and flag registers are 0, irq is low, and all four active volumes are 0.
- R2: Writing port 0 loads the bank index from hwdata[1:0], and the other written bits are ignored. Reading port 0 returns a status byte: bits 1:0 hold the bank, bit 2 is parameter FIFO empty, bit 3 is parameter FIFO full, bit 4 is response FIFO empty, bit 5 is data FIFO empty, bit 6 is command busy, and bit 7 is 0.
- R3: Reading port 1 in any bank returns the oldest response byte and removes it. A read from an empty response FIFO returns 0 and removes nothing.
- R4: Writing port 1 in bank 0 makes cmd_valid high for exactly the next cycle, with cmd_byte equal to the written byte. It also sets busy, which stays set until cmd_ack is seen.
- R5: Reading port 2 in any bank removes data FIFO bytes. With hhalf low it returns one byte in hrdata[7:0]. With hhalf high it returns the oldest byte in hrdata[7:0] and the next one in hrdata[15:8], and removes both. A missing byte reads as 0.
- R6: Writing port 2 in bank 0 appends to a 16-entry parameter FIFO, and a write when the FIFO is full is dropped. The drive side reads the parameters in order through prm_data/prm_avail and pops them with prm_rd.
- R7: Writing port 2 in bank 1 loads the interrupt enable register (the low 5 bits). Reading port 3 returns the enable register in banks 0 and 2 and the flag register in banks 1 and 3, zero-extended.
- R8: A high bit on flag_set sets the matching flag bit. Writing port 3 in bank 1 or 3 clears every flag bit written as 1. If a set and a clear of the same bit happen in the same cycle, the set wins.
- R9: irq is high exactly while some flag bit and its enable bit are both 1.
- R10: Volume writes are staged: port 2 in bank 2 is left-to-left, port 3 in bank 2 is left-to-right, port 2 in bank 3 is right-to-left, and port 1 in bank 3 is right-to-right. The active outputs keep their values until a write to port 3 in bank 3 has bit 5 set. Then all four staged values appear on the outputs in the next cycle.
- R11: Writing port 3 in bank 0 makes req_valid high for exactly the next cycle, with req_byte equal to the written byte.
- R12: A port 1 write in bank 1 or 2 has no effect: no command strobe, no busy, and no change to any staged or active volume.
- R13: The response FIFO holds 16 bytes, and a push when it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hwr | input | 1 | Host write strobe |
| hrd | input | 1 | Host read strobe (pops FIFOs at the clock edge) |
| haddr | input | 2 | Host port address |
| hwdata | input | 8 | Host write byte |
| hhalf | input | 1 | Halfword read of the data FIFO |
| hrdata | output | 16 | Host read data, valid during hrd |
| rsp_push | input | 1 | Drive pushes a response byte |
| rsp_byte | input | 8 | Response byte |
| dat_push | input | 1 | Drive pushes a sector data byte |
| dat_byte | input | 8 | Sector data byte |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command code |
| cmd_ack | input | 1 | Drive accepted the command, clears busy |
| prm_rd | input | 1 | Drive pops one parameter byte |
| prm_avail | output | 1 | Parameter FIFO not empty |
| prm_data | output | 8 | Oldest parameter byte |
| req_valid | output | 1 | One-cycle request strobe |
| req_byte | output | 8 | Request byte |
| flag_set | input | 5 | Per-bit interrupt flag set |
| irq | output | 1 | Interrupt request |
| vol_ll | output | 8 | Active left-to-left volume |
| vol_lr | output | 8 | Active left-to-right volume |
| vol_rl | output | 8 | Active right-to-left volume |
| vol_rr | output | 8 | Active right-to-right volume |

## Verification
The bench sweeps every bank for each port. A decode that ignored the bank would issue commands from bank 1 or 2, or put a volume into the wrong slot. The bench fills the parameter and response FIFOs to 16 and pushes one byte more. A pointer or count that wrapped would then return a stale byte or lose the first one. Halfword reads are run with an odd number of bytes left, so a design that popped two anyway would underflow its count. The bench writes the apply register without bit 5 and stages a volume after an apply; an output that followed the staging register would move early. It also sets and clears the same flag bit in one cycle, which catches a clear that takes priority over the set.

// File: rtl/drv_regif_pkg.sv
package drv_regif_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PORT_IDX = 2'd0,
    PORT_RSP = 2'd1,
    PORT_DAT = 2'd2,
    PORT_IRQ = 2'd3
  } port_e;

  // status byte bit positions on port 0
  localparam int ST_PRM_EMPTY = 2;
  localparam int ST_PRM_FULL  = 3;
  localparam int ST_RSP_EMPTY = 4;
  localparam int ST_DAT_EMPTY = 5;
  localparam int ST_BUSY      = 6;

  // apply strobe bit in the bank 3 port 3 write
  localparam int APPLY_BIT = 5;

  // volume slot indices
  localparam int VOL_LL = 0;
  localparam int VOL_LR = 1;
  localparam int VOL_RL = 2;
  localparam int VOL_RR = 3;
  localparam int VOL_N  = 4;
endpackage

// File: rtl/drv_fifo.sv
module drv_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int PEEK  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic [1:0]               pop_cnt,
  output logic [PEEK*W-1:0]        peek,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] pop_amt;
  logic          do_push;

  always_comb begin
    do_push  = push && (cnt_q != CW'(DEPTH));
    pop_amt  = (CW'(pop_cnt) > cnt_q) ? cnt_q : CW'(pop_cnt);
    wr_ptr_d = do_push ? wr_ptr_q + AW'(1) : wr_ptr_q;
    rd_ptr_d = rd_ptr_q + AW'(pop_amt);
    cnt_d    = cnt_q + CW'(do_push) - pop_amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  for (genvar k = 0; k < PEEK; k++) begin : g_peek
    logic [AW-1:0] idx;
    assign idx = rd_ptr_q + AW'(k);
    assign peek[k*W +: W] = (cnt_q > CW'(k)) ? mem[idx] : '0;
  end

  assign count = cnt_q;
endmodule

// File: rtl/drv_irq_ctl.sv
module drv_irq_ctl #(
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ie_we,
  input  logic [FLAG_W-1:0] ie_wdata,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_mask,
  input  logic [FLAG_W-1:0] set_vec,
  output logic [FLAG_W-1:0] ie,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  logic [FLAG_W-1:0] ie_q, ie_d, flg_q, flg_d;

  always_comb begin
    ie_d  = ie_we ? ie_wdata : ie_q;
    flg_d = (flg_q & ~(clr_we ? clr_mask : '0)) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= '0;
      flg_q <= '0;
    end else begin
      ie_q  <= ie_d;
      flg_q <= flg_d;
    end
  end

  assign ie    = ie_q;
  assign flags = flg_q;
  assign irq   = |(flg_q & ie_q);
endmodule

// File: rtl/drv_vol_stage.sv
module drv_vol_stage
  import drv_regif_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [VOL_N-1:0]            stage_we,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic                        apply,
  output logic [VOL_N-1:0][BYTE_W-1:0] active
);
  for (genvar c = 0; c < VOL_N; c++) begin : g_ch
    logic [BYTE_W-1:0] stg_q, stg_d, act_q, act_d;

    always_comb begin
      stg_d = stage_we[c] ? wdata : stg_q;
      act_d = apply ? stg_q : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
        act_q <= '0;
      end else begin
        stg_q <= stg_d;
        act_q <= act_d;
      end
    end

    assign active[c] = act_q;
  end
endmodule

// File: rtl/drv_regif.sv
module drv_regif
  import drv_regif_pkg::*;
#(
  parameter int PRM_DEPTH = 16,
  parameter int RSP_DEPTH = 16,
  parameter int DAT_DEPTH = 16,
  parameter int FLAG_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hwr,
  input  logic              hrd,
  input  logic [1:0]        haddr,
  input  logic [7:0]        hwdata,
  input  logic              hhalf,
  output logic [15:0]       hrdata,
  input  logic              rsp_push,
  input  logic [7:0]        rsp_byte,
  input  logic              dat_push,
  input  logic [7:0]        dat_byte,
  output logic              cmd_valid,
  output logic [7:0]        cmd_byte,
  input  logic              cmd_ack,
  input  logic              prm_rd,
  output logic              prm_avail,
  output logic [7:0]        prm_data,
  output logic              req_valid,
  output logic [7:0]        req_byte,
  input  logic [FLAG_W-1:0] flag_set,
  output logic              irq,
  output logic [7:0]        vol_ll,
  output logic [7:0]        vol_lr,
  output logic [7:0]        vol_rl,
  output logic [7:0]        vol_rr
);
  localparam int PCW = $clog2(PRM_DEPTH) + 1;
  localparam int RCW = $clog2(RSP_DEPTH) + 1;
  localparam int DCW = $clog2(DAT_DEPTH) + 1;

  // ---------------- decode ----------------
  logic [1:0] bank_q, bank_d;
  logic wr_idx, wr_rsp, wr_dat, wr_irq;
  logic cmd_we, prm_push, ie_we, req_we, clr_we, apply;
  logic [VOL_N-1:0] vol_we;
  logic rsp_pop;
  logic [1:0] dat_pop;

  always_comb begin
    wr_idx   = hwr && (haddr == PORT_IDX);
    wr_rsp   = hwr && (haddr == PORT_RSP);
    wr_dat   = hwr && (haddr == PORT_DAT);
    wr_irq   = hwr && (haddr == PORT_IRQ);
    bank_d   = wr_idx ? hwdata[1:0] : bank_q;

    cmd_we   = wr_rsp && (bank_q == 2'd0);
    prm_push = wr_dat && (bank_q == 2'd0);
    ie_we    = wr_dat && (bank_q == 2'd1);
    req_we   = wr_irq && (bank_q == 2'd0);
    clr_we   = wr_irq && bank_q[0];
    apply    = wr_irq && (bank_q == 2'd3) && hwdata[APPLY_BIT];

    vol_we         = '0;
    vol_we[VOL_LL] = wr_dat && (bank_q == 2'd2);
    vol_we[VOL_LR] = wr_irq && (bank_q == 2'd2);
    vol_we[VOL_RL] = wr_dat && (bank_q == 2'd3);
    vol_we[VOL_RR] = wr_rsp && (bank_q == 2'd3);

    rsp_pop  = hrd && (haddr == PORT_RSP);
    dat_pop  = (hrd && (haddr == PORT_DAT)) ? (hhalf ? 2'd2 : 2'd1) : 2'd0;
  end

  // ---------------- command / request / busy ----------------
  logic       busy_q, busy_d;
  logic       cmd_v_q, cmd_v_d, req_v_q, req_v_d;
  logic [7:0] cmd_b_q, cmd_b_d, req_b_q, req_b_d;

  always_comb begin
    busy_d  = cmd_we ? 1'b1 : (cmd_ack ? 1'b0 : busy_q);
    cmd_v_d = cmd_we;
    cmd_b_d = cmd_we ? hwdata : cmd_b_q;
    req_v_d = req_we;
    req_b_d = req_we ? hwdata : req_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      busy_q  <= 1'b0;
      cmd_v_q <= 1'b0;
      cmd_b_q <= '0;
      req_v_q <= 1'b0;
      req_b_q <= '0;
    end else begin
      bank_q  <= bank_d;
      busy_q  <= busy_d;
      cmd_v_q <= cmd_v_d;
      cmd_b_q <= cmd_b_d;
      req_v_q <= req_v_d;
      req_b_q <= req_b_d;
    end
  end

  assign cmd_valid = cmd_v_q;
  assign cmd_byte  = cmd_b_q;
  assign req_valid = req_v_q;
  assign req_byte  = req_b_q;

  // ---------------- FIFOs ----------------
  logic [7:0]     prm_head, rsp_head;
  logic [15:0]    dat_peek;
  logic [PCW-1:0] prm_cnt;
  logic [RCW-1:0] rsp_cnt;
  logic [DCW-1:0] dat_cnt;

  drv_fifo #(.W(BYTE_W), .DEPTH(PRM_DEPTH), .PEEK(1)) u_prm (
    .clk(clk), .rst_n(rst_n), .push(prm_push), .din(hwdata),
    .pop_cnt({1'b0, prm_rd}), .peek(prm_head), .count(prm_cnt)
  );

  drv_fifo #(.W(BYTE_W), .DEPTH(RSP_DEPTH), .PEEK(1)) u_rsp (
    .clk(clk), .rst_n(rst_n), .push(rsp_push), .din(rsp_byte),
    .pop_cnt({1'b0, rsp_pop}), .peek(rsp_head), .count(rsp_cnt)
  );

  drv_fifo #(.W(BYTE_W), .DEPTH(DAT_DEPTH), .PEEK(2)) u_dat (
    .clk(clk), .rst_n(rst_n), .push(dat_push), .din(dat_byte),
    .pop_cnt(dat_pop), .peek(dat_peek), .count(dat_cnt)
  );

  logic prm_empty, prm_full, rsp_empty, dat_empty;
  assign prm_empty = (prm_cnt == '0);
  assign prm_full  = (prm_cnt == PCW'(PRM_DEPTH));
  assign rsp_empty = (rsp_cnt == '0);
  assign dat_empty = (dat_cnt == '0);
  assign prm_avail = !prm_empty;
  assign prm_data  = prm_head;

  // ---------------- interrupts ----------------
  logic [FLAG_W-1:0] ie_w, flags_w;

  drv_irq_ctl #(.FLAG_W(FLAG_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .ie_we(ie_we), .ie_wdata(hwdata[FLAG_W-1:0]),
    .clr_we(clr_we), .clr_mask(hwdata[FLAG_W-1:0]),
    .set_vec(flag_set), .ie(ie_w), .flags(flags_w), .irq(irq)
  );

  // ---------------- volumes ----------------
  logic [VOL_N-1:0][BYTE_W-1:0] vol_act;

  drv_vol_stage u_vol (
    .clk(clk), .rst_n(rst_n), .stage_we(vol_we), .wdata(hwdata),
    .apply(apply), .active(vol_act)
  );

  assign vol_ll = vol_act[VOL_LL];
  assign vol_lr = vol_act[VOL_LR];
  assign vol_rl = vol_act[VOL_RL];
  assign vol_rr = vol_act[VOL_RR];

  // ---------------- read mux ----------------
  logic [7:0] status;

  always_comb begin
    status               = '0;
    status[1:0]          = bank_q;
    status[ST_PRM_EMPTY] = prm_empty;
    status[ST_PRM_FULL]  = prm_full;
    status[ST_RSP_EMPTY] = rsp_empty;
    status[ST_DAT_EMPTY] = dat_empty;
    status[ST_BUSY]      = busy_q;

    hrdata = '0;
    if (hrd) begin
      unique case (haddr)
        PORT_IDX: hrdata = {8'h00, status};
        PORT_RSP: hrdata = {8'h00, rsp_head};
        PORT_DAT: hrdata = hhalf ? dat_peek : {8'h00, dat_peek[7:0]};
        default:  hrdata = {8'h00, 8'(bank_q[0] ? flags_w : ie_w)};
      endcase
    end
  end
endmodule

// File: rtl/drv_regif_chk.sv
module drv_regif_chk #(
  parameter int FLAG_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hwr,
  input logic [1:0]        haddr,
  input logic [7:0]        hwdata,
  input logic [1:0]        bank,
  input logic              cmd_valid,
  input logic [7:0]        cmd_byte,
  input logic              cmd_ack,
  input logic              busy,
  input logic              req_valid,
  input logic [7:0]        req_byte,
  input logic [7:0]        vol_ll,
  input logic [7:0]        vol_lr,
  input logic [7:0]        vol_rl,
  input logic [7:0]        vol_rr,
  input logic [FLAG_W-1:0] ie,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] flag_set,
  input logic              irq,
  input logic              prm_full,
  input logic              prm_rd
);
  logic cmd_wr, req_wr, apply_wr;
  assign cmd_wr   = hwr && (haddr == 2'd1) && (bank == 2'd0);
  assign req_wr   = hwr && (haddr == 2'd3) && (bank == 2'd0);
  assign apply_wr = hwr && (haddr == 2'd3) && (bank == 2'd3) && hwdata[5];

  a_r4_cmd_issue: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cmd_valid && cmd_byte == $past(hwdata)));

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_ack) |=> busy);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack && !cmd_wr) |=> !busy);

  a_r12_no_cmd_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr && haddr == 2'd1 && bank != 2'd0) |=> !cmd_valid);

  a_r11_req_issue: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |=> (req_valid && req_byte == $past(hwdata)));

  a_r10_vol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_wr |=> ($stable(vol_ll) && $stable(vol_lr) && $stable(vol_rl) && $stable(vol_rr)));

  a_r8_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set)));

  a_r9_no_irq_unenabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == '0) |-> !irq);

  a_r6_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (prm_full && !prm_rd) |=> prm_full);
endmodule

bind drv_regif drv_regif_chk #(.FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hwr(hwr), .haddr(haddr), .hwdata(hwdata),
  .bank(bank_q), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ack(cmd_ack),
  .busy(busy_q), .req_valid(req_valid), .req_byte(req_byte),
  .vol_ll(vol_ll), .vol_lr(vol_lr), .vol_rl(vol_rl), .vol_rr(vol_rr),
  .ie(ie_w), .flags(flags_w), .flag_set(flag_set), .irq(irq),
  .prm_full(prm_full), .prm_rd(prm_rd)
);

// File: tb/drv_regif_tb.sv
`timescale 1ns/1ps
module drv_regif_tb;
  logic clk, rst_n;
  logic hwr, hrd, hhalf;
  logic [1:0] haddr;
  logic [7:0] hwdata;
  logic [15:0] hrdata;
  logic rsp_push, dat_push, cmd_valid, cmd_ack, prm_rd, prm_avail, req_valid, irq;
  logic [7:0] rsp_byte, dat_byte, cmd_byte, prm_data, req_byte;
  logic [4:0] flag_set;
  logic [7:0] vol_ll, vol_lr, vol_rl, vol_rr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  drv_regif u_dut (
    .clk(clk), .rst_n(rst_n), .hwr(hwr), .hrd(hrd), .haddr(haddr), .hwdata(hwdata),
    .hhalf(hhalf), .hrdata(hrdata), .rsp_push(rsp_push), .rsp_byte(rsp_byte),
    .dat_push(dat_push), .dat_byte(dat_byte), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_ack(cmd_ack), .prm_rd(prm_rd), .prm_avail(prm_avail), .prm_data(prm_data),
    .req_valid(req_valid), .req_byte(req_byte), .flag_set(flag_set), .irq(irq),
    .vol_ll(vol_ll), .vol_lr(vol_lr), .vol_rl(vol_rl), .vol_rr(vol_rr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input logic [1:0] b, input bit pe, input bit pf,
                                    input bit re, input bit de, input bit bz);
    return {1'b0, bz, de, re, pf, pe, b};
  endfunction

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk); hwr = 1'b1; haddr = p; hwdata = d;
    @(negedge clk); hwr = 1'b0; hwdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] p, input bit h, output logic [15:0] d);
    @(negedge clk); hrd = 1'b1; haddr = p; hhalf = h;
    #1 d = hrdata;
    @(negedge clk); hrd = 1'b0; hhalf = 1'b0;
  endtask

  task automatic push_rsp(input logic [7:0] b);
    @(negedge clk); rsp_push = 1'b1; rsp_byte = b;
    @(negedge clk); rsp_push = 1'b0;
  endtask

  task automatic push_dat(input logic [7:0] b);
    @(negedge clk); dat_push = 1'b1; dat_byte = b;
    @(negedge clk); dat_push = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; hwr = 0; hrd = 0; hhalf = 0; haddr = 0; hwdata = 0;
    rsp_push = 0; rsp_byte = 0; dat_push = 0; dat_byte = 0; cmd_ack = 0;
    prm_rd = 0; flag_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 0, d);
    chk("R1 status", d, {8'h00, st(2'd0, 1, 0, 1, 1, 0)});
    chk("R1 vols", {vol_ll, vol_lr, vol_rl, vol_rr}, 32'h0);
    chk("R1 irq/cmd/req", {irq, cmd_valid, req_valid, prm_avail}, 4'b0000);

    // R2 bank sweep, upper written bits ignored
    for (int b = 0; b < 4; b++) begin
      wr(2'd0, 8'hA8 | 8'(b));
      rd(2'd0, 0, d);
      chk("R2 bank status", d, {8'h00, st(2'(b), 1, 0, 1, 1, 0)});
    end

    // R10 stage all four volumes, outputs hold
    wr(2'd0, 8'd2);
    wr(2'd2, 8'h11);
    wr(2'd3, 8'h22);
    wr(2'd0, 8'd3);
    wr(2'd2, 8'h33);
    wr(2'd1, 8'h44);
    chk("R10 staged not active", {vol_ll, vol_lr, vol_rl, vol_rr}, 32'h0);

    // R12 port 1 writes in banks 1 and 2 are ignored
    for (int b = 1; b < 3; b++) begin
      wr(2'd0, 8'(b));
      @(negedge clk); hwr = 1; haddr = 2'd1; hwdata = 8'h99;
      @(negedge clk); hwr = 0;
      chk("R12 no cmd strobe", cmd_valid, 1'b0);
      rd(2'd0, 0, d);
      chk("R12 no busy", d[6], 1'b0);
    end

    // apply bit clear: no effect
    wr(2'd0, 8'd3);
    wr(2'd3, 8'h00);
    chk("R10 no apply without bit5", {vol_ll, vol_lr, vol_rl, vol_rr}, 32'h0);
    wr(2'd3, 8'h20);
    chk("R10 apply copies all", {vol_ll, vol_lr, vol_rl, vol_rr}, 32'h11223344);
    chk("R12 rr not overwritten", vol_rr, 8'h44);
    wr(2'd0, 8'd2);
    wr(2'd2, 8'h55);
    chk("R10 active holds after restage", vol_ll, 8'h11);
    wr(2'd0, 8'd3);
    wr(2'd3, 8'h3F);
    chk("R10 second apply", {vol_ll, vol_lr, vol_rl, vol_rr}, 32'h55223344);

    // R4 command
    wr(2'd0, 8'd0);
    @(negedge clk); hwr = 1; haddr = 2'd1; hwdata = 8'hA5;
    @(negedge clk); hwr = 0;
    chk("R4 cmd strobe", {cmd_valid, cmd_byte}, {1'b1, 8'hA5});
    @(negedge clk);
    chk("R4 strobe one cycle", cmd_valid, 1'b0);
    rd(2'd0, 0, d);
    chk("R4 busy set", d, {8'h00, st(2'd0, 1, 0, 1, 1, 1)});
    repeat (3) @(negedge clk);
    rd(2'd0, 0, d);
    chk("R4 busy held", d[6], 1'b1);
    @(negedge clk); cmd_ack = 1;
    @(negedge clk); cmd_ack = 0;
    rd(2'd0, 0, d);
    chk("R4 busy cleared by ack", d[6], 1'b0);

    // R11 request
    @(negedge clk); hwr = 1; haddr = 2'd3; hwdata = 8'h5A;
    @(negedge clk); hwr = 0;
    chk("R11 req strobe", {req_valid, req_byte}, {1'b1, 8'h5A});
    @(negedge clk);
    chk("R11 one cycle", req_valid, 1'b0);

    // R6 parameter FIFO fill past full
    for (int i = 0; i < 17; i++) wr(2'd2, 8'h80 + 8'(i));
    rd(2'd0, 0, d);
    chk("R6 full status", d, {8'h00, st(2'd0, 0, 1, 1, 1, 0)});
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R6 prm order", {prm_avail, prm_data}, {1'b1, 8'h80 + 8'(i)});
      prm_rd = 1;
      @(negedge clk); prm_rd = 0;
    end
    chk("R6 drained", prm_avail, 1'b0);

    // R13 / R3 response FIFO
    for (int i = 0; i < 17; i++) push_rsp(8'h40 + 8'(i));
    wr(2'd0, 8'd2);
    rd(2'd0, 0, d);
    chk("R13 rsp not empty", d[4], 1'b0);
    for (int i = 0; i < 16; i++) begin
      rd(2'd1, 0, d);
      chk("R3 rsp order", d, {8'h00, 8'h40 + 8'(i)});
    end
    rd(2'd1, 0, d);
    chk("R13 overflow dropped, empty reads 0", d, 16'h0);
    rd(2'd0, 0, d);
    chk("R3 rsp empty", d[4], 1'b1);

    // R5 data FIFO byte and halfword reads
    for (int i = 0; i < 7; i++) push_dat(8'hC0 + 8'(i));
    wr(2'd0, 8'd1);
    rd(2'd2, 0, d);
    chk("R5 byte read", d, 16'h00C0);
    for (int i = 0; i < 3; i++) begin
      rd(2'd2, 1, d);
      chk("R5 half read", d, {8'hC2 + 8'(2*i), 8'hC1 + 8'(2*i)});
    end
    rd(2'd0, 0, d);
    chk("R5 dat empty", d[5], 1'b1);
    push_dat(8'hEE);
    rd(2'd2, 1, d);
    chk("R5 half with one byte", d, 16'h00EE);
    push_dat(8'h12);
    rd(2'd2, 0, d);
    chk("R5 no underflow", d, 16'h0012);

    // R7 / R8 / R9 interrupts (bank 1)
    wr(2'd2, 8'h05);
    rd(2'd3, 0, d);
    chk("R7 flags zero", d, 16'h0);
    @(negedge clk); flag_set = 5'b00110;
    @(negedge clk); flag_set = '0;
    rd(2'd3, 0, d);
    chk("R8 flags set", d, 16'h0006);
    chk("R9 irq on", irq, 1'b1);
    wr(2'd0, 8'd0);
    rd(2'd3, 0, d);
    chk("R7 enable readback bank0", d, 16'h0005);
    wr(2'd0, 8'd2);
    rd(2'd3, 0, d);
    chk("R7 enable readback bank2", d, 16'h0005);
    wr(2'd0, 8'd3);
    wr(2'd3, 8'h04);
    rd(2'd3, 0, d);
    chk("R8 clear bit2", d, 16'h0002);
    chk("R9 irq off", irq, 1'b0);
    wr(2'd3, 8'h02);
    rd(2'd3, 0, d);
    chk("R8 cleared all", d, 16'h0);
    @(negedge clk); flag_set = 5'b00010; hwr = 1; haddr = 2'd3; hwdata = 8'h02;
    @(negedge clk); flag_set = '0; hwr = 0;
    rd(2'd3, 0, d);
    chk("R8 set wins", d, 16'h0002);
    chk("R9 unenabled flag no irq", irq, 1'b0);
    wr(2'd0, 8'd1);
    wr(2'd2, 8'h02);
    chk("R9 irq after enable", irq, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule